// File: doc/BRIEF.md
# Five-Tuple Flow Classifier with Metadata Prefix

This block is the common front stage of a packet pipeline. It takes a byte stream of Ethernet frames, picks out the IPv4 protocol, addresses and (for TCP and UDP) ports, and compares that five-tuple with a small table of masked rules. Every frame leaves with a six-byte metadata prefix in front of it. The prefix carries a flow number, an ordered chain of downstream function numbers and a forwarding action, so later stages act on the prefix and do not parse headers again.

Software fills the table through a write-only register port, one 32-bit field per write. Each rule has a valid flag. A replacement rule can be written in full at a lower index and then switched on, while the older rule keeps matching until that moment. Frames that match nothing, that are not IPv4 or that end before their key bytes are complete get a default prefix.

Top module: `flow_tagger`

## Requirements
- R1: After reset `in_ready` is 1, `out_valid` is 0 and every table entry is invalid, so the first frame gets the miss prefix.
- R2: Each frame is output as six prefix bytes followed by the original frame bytes, unchanged and in order. The prefix bytes are, in order: fid[15:8], fid[7:0], path[15:8], path[7:0], {6'b0, action}, {hit, 1'b0, index[5:0]}. `out_sop` is set only on the first prefix byte and `out_eop` only on the last frame byte.
- R3: The key is taken at these byte offsets: ethertype at 12–13, version/IHL at 14, protocol at 23, source address at 26–29 and destination address at 30–33. For protocol 6 or 17 the source and destination ports are at 14+4·IHL and 16+4·IHL. For any other protocol both ports are treated as zero.
- R4: An entry hits when it is valid and, for each of the five fields, (key XOR entry) AND mask is zero. A mask bit of 1 means that bit is compared.
- R5: When several entries hit, the one with the lowest index supplies the prefix.
- R6: An entry with valid flag 0 never hits, even if its key matches. Clearing the flag makes a frame that used to hit fall through to the next match or to a miss.
- R7: On a miss the prefix holds fid 0, path 0, hit 0, index 0 and the action from the default-action register. That register resets to 0.
- R8: A frame whose ethertype is not 0x0800, whose version is not 4, whose IHL is below 5, or that ends before its last key byte gets the miss prefix. Its bytes are still forwarded intact.
- R9: While `out_ready` is 0 the output holds its byte and flags. No byte is lost or repeated, and input is stalled instead.
- R10: A configuration write (`cfg_wr`=1) selects the field with `cfg_sel`: 0 source address, 1 source mask, 2 destination address, 3 destination mask, 4 {src port, dst port}, 5 {src port mask, dst port mask}, 6 {protocol mask in [15:8], protocol in [7:0]}, 7 {fid in [31:16], path in [15:0]}, 8 {action in [2:1], valid in [0]}, 15 default action in [1:0] (the index is ignored for select 15).
- R11: The action code is 0 for forward-to-port, 1 for send-to-CPU and 2 for drop. It is copied from the entry unchanged. The path holds four 4-bit slots, with slot 0 in bits [3:0] as the next function and 0 meaning empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input byte valid |
| in_ready | output | 1 | Block accepts the input byte |
| in_data | input | 8 | Input frame byte |
| in_sop | input | 1 | First byte of a frame |
| in_eop | input | 1 | Last byte of a frame |
| out_valid | output | 1 | Output byte valid |
| out_ready | input | 1 | Downstream accepts the output byte |
| out_data | output | 8 | Output byte (prefix or frame) |
| out_sop | output | 1 | First prefix byte |
| out_eop | output | 1 | Last frame byte |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_idx | input | IDXW | Entry index for the write |
| cfg_sel | input | 4 | Field selector |
| cfg_wdata | input | 32 | Write data |

## Verification
The hardest case to reach from the ports is a port field at a shifted offset. With IHL 6, the four option bytes sit exactly where the ports would be with IHL 5. The stimulus fills them with a value no rule accepts, so a fixed-offset parser would miss. A second frame puts port-like bytes behind an ICMP header and relies on a rule that requires zero ports. Priority and invalidation are reached by making two overlapping rules live and then clearing the lower one between frames. Random output stalls are applied to frames that end in the prefix, in the buffered header and in the pass-through part.

// File: rtl/flow_tagger.sv
`timescale 1ns/1ps
module flow_tagger #(
  parameter int ENTRIES = 32,
  localparam int IDXW = $clog2(ENTRIES)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  output logic            in_ready,
  input  logic [7:0]      in_data,
  input  logic            in_sop,
  input  logic            in_eop,
  output logic            out_valid,
  input  logic            out_ready,
  output logic [7:0]      out_data,
  output logic            out_sop,
  output logic            out_eop,
  input  logic            cfg_wr,
  input  logic [IDXW-1:0] cfg_idx,
  input  logic [3:0]      cfg_sel,
  input  logic [31:0]     cfg_wdata
);
  localparam int BUF_DEPTH = 78;
  localparam int MBYTES = 6;

  typedef enum logic [2:0] {S_COLLECT, S_LOOK, S_META, S_DRAIN, S_PASS} st_t;
  st_t st;

  logic [31:0] e_sip [ENTRIES];
  logic [31:0] e_sipm[ENTRIES];
  logic [31:0] e_dip [ENTRIES];
  logic [31:0] e_dipm[ENTRIES];
  logic [15:0] e_sp  [ENTRIES];
  logic [15:0] e_dp  [ENTRIES];
  logic [15:0] e_spm [ENTRIES];
  logic [15:0] e_dpm [ENTRIES];
  logic [7:0]  e_pr  [ENTRIES];
  logic [7:0]  e_prm [ENTRIES];
  logic [15:0] e_fid [ENTRIES];
  logic [15:0] e_path[ENTRIES];
  logic [1:0]  e_act [ENTRIES];
  logic [ENTRIES-1:0] e_v;
  logic [1:0]  dflt_act;

  logic [15:0] k_et, k_sp, k_dp;
  logic [7:0]  k_vi, k_pr;
  logic [31:0] k_sip, k_dip;

  logic [7:0] bufm [BUF_DEPTH];
  logic [6:0] cnt, rd, idx, need, l4off;
  logic       ended, full;
  logic [2:0] mb;

  logic [15:0] m_fid, m_path;
  logic [1:0]  m_act;
  logic        m_hit;
  logic [IDXW-1:0] m_idx;

  logic unused_bits;
  assign unused_bits = ^cfg_wdata;

  wire acc = in_valid && in_ready;
  wire ihl_ok = k_vi[3:0] >= 4'd5;
  wire tcpudp = ihl_ok && (k_pr == 8'd6 || k_pr == 8'd17);
  assign l4off = 7'd14 + {1'b0, k_vi[3:0], 2'b00};
  assign need  = tcpudp ? l4off + 7'd4 : 7'd34;
  assign idx   = in_sop ? 7'd0 : cnt;
  wire last_key = (idx == need - 7'd1);
  wire elig = full && k_et == 16'h0800 && k_vi[7:4] == 4'd4 && ihl_ok;

  logic [ENTRIES-1:0] hit;
  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign hit[g] = e_v[g]
      && (((k_sip ^ e_sip[g]) & e_sipm[g]) == 32'd0)
      && (((k_dip ^ e_dip[g]) & e_dipm[g]) == 32'd0)
      && (((k_sp  ^ e_sp[g])  & e_spm[g])  == 16'd0)
      && (((k_dp  ^ e_dp[g])  & e_dpm[g])  == 16'd0)
      && (((k_pr  ^ e_pr[g])  & e_prm[g])  == 8'd0);
  end

  logic any;
  logic [IDXW-1:0] win;
  always_comb begin
    any = 1'b0;
    win = '0;
    for (int i = ENTRIES - 1; i >= 0; i--)
      if (hit[i]) begin
        any = 1'b1;
        win = IDXW'(i);
      end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dflt_act <= 2'd0;
      e_v <= '0;
      for (int i = 0; i < ENTRIES; i++) begin
        e_sip[i] <= '0; e_sipm[i] <= '0; e_dip[i] <= '0; e_dipm[i] <= '0;
        e_sp[i] <= '0; e_dp[i] <= '0; e_spm[i] <= '0; e_dpm[i] <= '0;
        e_pr[i] <= '0; e_prm[i] <= '0; e_fid[i] <= '0; e_path[i] <= '0;
        e_act[i] <= '0;
      end
    end else if (cfg_wr) begin
      case (cfg_sel)
        4'd0: e_sip[cfg_idx]  <= cfg_wdata;
        4'd1: e_sipm[cfg_idx] <= cfg_wdata;
        4'd2: e_dip[cfg_idx]  <= cfg_wdata;
        4'd3: e_dipm[cfg_idx] <= cfg_wdata;
        4'd4: begin e_sp[cfg_idx] <= cfg_wdata[31:16]; e_dp[cfg_idx] <= cfg_wdata[15:0]; end
        4'd5: begin e_spm[cfg_idx] <= cfg_wdata[31:16]; e_dpm[cfg_idx] <= cfg_wdata[15:0]; end
        4'd6: begin e_prm[cfg_idx] <= cfg_wdata[15:8]; e_pr[cfg_idx] <= cfg_wdata[7:0]; end
        4'd7: begin e_fid[cfg_idx] <= cfg_wdata[31:16]; e_path[cfg_idx] <= cfg_wdata[15:0]; end
        4'd8: begin e_act[cfg_idx] <= cfg_wdata[2:1]; e_v[cfg_idx] <= cfg_wdata[0]; end
        4'd15: dflt_act <= cfg_wdata[1:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (st == S_COLLECT && acc && idx < 7'(BUF_DEPTH))
      bufm[idx] <= in_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      k_et <= '0; k_vi <= '0; k_pr <= '0; k_sip <= '0; k_dip <= '0;
      k_sp <= '0; k_dp <= '0;
    end else if (st == S_COLLECT && acc) begin
      if (idx == 7'd0) begin
        k_et <= '0; k_vi <= '0; k_pr <= '0; k_sip <= '0; k_dip <= '0;
        k_sp <= '0; k_dp <= '0;
      end
      if (idx == 7'd12 || idx == 7'd13) k_et <= {k_et[7:0], in_data};
      if (idx == 7'd14) k_vi <= in_data;
      if (idx == 7'd23) k_pr <= in_data;
      if (idx >= 7'd26 && idx <= 7'd29) k_sip <= {k_sip[23:0], in_data};
      if (idx >= 7'd30 && idx <= 7'd33) k_dip <= {k_dip[23:0], in_data};
      if (tcpudp && (idx == l4off || idx == l4off + 7'd1)) k_sp <= {k_sp[7:0], in_data};
      if (tcpudp && (idx == l4off + 7'd2 || idx == l4off + 7'd3)) k_dp <= {k_dp[7:0], in_data};
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_COLLECT; cnt <= '0; rd <= '0; mb <= '0; ended <= 1'b0; full <= 1'b0;
      m_fid <= '0; m_path <= '0; m_act <= '0; m_hit <= 1'b0; m_idx <= '0;
    end else begin
      case (st)
        S_COLLECT: if (acc) begin
          cnt <= idx + 7'd1;
          if (last_key || in_eop) begin
            ended <= in_eop;
            full  <= last_key;
            st    <= S_LOOK;
          end
        end
        S_LOOK: begin
          if (elig && any) begin
            m_fid <= e_fid[win]; m_path <= e_path[win]; m_act <= e_act[win];
            m_hit <= 1'b1; m_idx <= win;
          end else begin
            m_fid <= '0; m_path <= '0; m_act <= dflt_act;
            m_hit <= 1'b0; m_idx <= '0;
          end
          mb <= '0;
          st <= S_META;
        end
        S_META: if (out_ready) begin
          mb <= mb + 3'd1;
          if (mb == 3'(MBYTES - 1)) begin
            rd <= '0;
            st <= S_DRAIN;
          end
        end
        S_DRAIN: if (out_ready) begin
          rd <= rd + 7'd1;
          if (rd == cnt - 7'd1) begin
            cnt <= '0;
            st  <= ended ? S_COLLECT : S_PASS;
          end
        end
        S_PASS: if (acc && in_eop) st <= S_COLLECT;
        default: st <= S_COLLECT;
      endcase
    end
  end

  logic [7:0] mbyte;
  always_comb begin
    case (mb)
      3'd0: mbyte = m_fid[15:8];
      3'd1: mbyte = m_fid[7:0];
      3'd2: mbyte = m_path[15:8];
      3'd3: mbyte = m_path[7:0];
      3'd4: mbyte = {6'd0, m_act};
      default: mbyte = {m_hit, 1'b0, 6'(m_idx)};
    endcase
  end

  always_comb begin
    in_ready = 1'b0; out_valid = 1'b0; out_data = '0; out_sop = 1'b0; out_eop = 1'b0;
    case (st)
      S_COLLECT: in_ready = 1'b1;
      S_META: begin
        out_valid = 1'b1; out_data = mbyte; out_sop = (mb == 3'd0);
      end
      S_DRAIN: begin
        out_valid = 1'b1; out_data = bufm[rd]; out_eop = ended && (rd == cnt - 7'd1);
      end
      S_PASS: begin
        out_valid = in_valid; in_ready = out_ready; out_data = in_data; out_eop = in_eop;
      end
      default: ;
    endcase
  end

  p_hold_out_r9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_sop) && $stable(out_eop));
  p_hit_taken_r4: assert property (@(posedge clk) disable iff (!rst_n)
    st == S_LOOK && elig && any |=> m_hit);
  p_miss_dflt_r7: assert property (@(posedge clk) disable iff (!rst_n)
    st == S_LOOK && !(elig && any) |=> !m_hit && m_fid == 16'd0 && m_path == 16'd0 && m_act == $past(dflt_act));
  p_bypass_r8: assert property (@(posedge clk) disable iff (!rst_n)
    st == S_LOOK && !elig |=> !m_hit);
  p_single_sop_r2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready && out_sop |=> !out_sop);
endmodule

// File: tb/sim_flow_tagger.sv
`timescale 1ns/1ps
module sim_flow_tagger;
  localparam int CLK_NS = 10;
  logic clk = 0, rst_n = 0;
  logic in_valid = 0, in_ready, in_sop = 0, in_eop = 0;
  logic [7:0] in_data = 0;
  logic out_valid, out_ready = 1, out_sop, out_eop;
  logic [7:0] out_data;
  logic cfg_wr = 0;
  logic [4:0] cfg_idx = 0;
  logic [3:0] cfg_sel = 0;
  logic [31:0] cfg_wdata = 0;

  flow_tagger u0 (.clk, .rst_n, .in_valid, .in_ready, .in_data, .in_sop, .in_eop,
    .out_valid, .out_ready, .out_data, .out_sop, .out_eop,
    .cfg_wr, .cfg_idx, .cfg_sel, .cfg_wdata);

  always #(CLK_NS/2) clk = ~clk;

  int errors = 0, checks = 0;
  logic [9:0] exp_q[$];
  string tag_q[$];
  logic [7:0] pk[$];
  logic bp_en = 0;
  logic [15:0] lfsr = 16'hACE1;
  bit done = 0;

  initial forever begin
    @(posedge clk); #1;
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    out_ready = bp_en ? lfsr[0] : 1'b1;
  end

  initial forever begin
    @(negedge clk);
    if (rst_n && out_valid && out_ready) begin
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL R2: unexpected byte got %02h sop=%0b eop=%0b, expected none", out_data, out_sop, out_eop);
      end else begin
        logic [9:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if ({out_sop, out_eop, out_data} !== e) begin
          errors++;
          $display("FAIL %s: got sop=%0b eop=%0b data=%02h, expected sop=%0b eop=%0b data=%02h",
                   t, out_sop, out_eop, out_data, e[9], e[8], e[7:0]);
        end
      end
    end
  end

  initial begin
    for (int c = 0; c < 150000; c++) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got hang, expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  task automatic mk(input [15:0] et, input [7:0] vi, input [7:0] pr, input [31:0] s, input [31:0] d,
                    input [15:0] sp, input [15:0] dp, input int tail);
    pk.delete();
    for (int i = 0; i < 12; i++) pk.push_back(8'(i + 1));
    pk.push_back(et[15:8]); pk.push_back(et[7:0]); pk.push_back(vi);
    for (int i = 15; i < 23; i++) pk.push_back(8'(i));
    pk.push_back(pr); pk.push_back(8'h00); pk.push_back(8'h00);
    for (int i = 3; i >= 0; i--) pk.push_back(s[i*8 +: 8]);
    for (int i = 3; i >= 0; i--) pk.push_back(d[i*8 +: 8]);
    for (int i = 5; i < int'(vi[3:0]); i++) repeat (4) pk.push_back(8'hEE);
    pk.push_back(sp[15:8]); pk.push_back(sp[7:0]); pk.push_back(dp[15:8]); pk.push_back(dp[7:0]);
    for (int i = 0; i < tail; i++) pk.push_back(8'(i) ^ 8'h5A);
  endtask

  task automatic send(input [15:0] fid, input [15:0] path, input [1:0] act, input bit hit,
                      input [5:0] ix, input string t);
    logic [7:0] m[6];
    m[0] = fid[15:8]; m[1] = fid[7:0]; m[2] = path[15:8]; m[3] = path[7:0];
    m[4] = {6'd0, act}; m[5] = {hit, 1'b0, ix};
    for (int i = 0; i < 6; i++) begin
      exp_q.push_back({(i == 0), 1'b0, m[i]}); tag_q.push_back(t);
    end
    for (int i = 0; i < pk.size(); i++) begin
      exp_q.push_back({1'b0, (i == pk.size() - 1), pk[i]}); tag_q.push_back({t, "/R2"});
    end
    for (int i = 0; i < pk.size(); i++) begin
      in_valid = 1; in_data = pk[i]; in_sop = (i == 0); in_eop = (i == pk.size() - 1);
      forever begin @(negedge clk); if (in_ready) break; end
      @(posedge clk); #1;
    end
    in_valid = 0; in_sop = 0; in_eop = 0;
  endtask

  task automatic wait_empty();
    while (exp_q.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic cw(input [4:0] ix, input [3:0] sel, input [31:0] d);
    @(posedge clk); #1;
    cfg_wr = 1; cfg_idx = ix; cfg_sel = sel; cfg_wdata = d;
    @(posedge clk); #1;
    cfg_wr = 0;
  endtask

  task automatic entry(input [4:0] ix, input [31:0] s, input [31:0] sm, input [31:0] d, input [31:0] dm,
                       input [15:0] sp, input [15:0] dp, input [15:0] spm, input [15:0] dpm,
                       input [7:0] pr, input [7:0] prm, input [15:0] fid, input [15:0] path,
                       input [1:0] act, input bit v);
    cw(ix, 4'd0, s); cw(ix, 4'd1, sm); cw(ix, 4'd2, d); cw(ix, 4'd3, dm);
    cw(ix, 4'd4, {sp, dp}); cw(ix, 4'd5, {spm, dpm}); cw(ix, 4'd6, {16'd0, prm, pr});
    cw(ix, 4'd7, {fid, path}); cw(ix, 4'd8, {29'd0, act, v});
  endtask

  localparam logic [31:0] SA = 32'hC0A80101, DA = 32'h0A000005;

  initial begin
    repeat (3) @(posedge clk); #1;
    rst_n = 1;
    @(negedge clk);
    checks++;
    if (in_ready !== 1'b1 || out_valid !== 1'b0) begin
      errors++;
      $display("FAIL R1: got in_ready=%0b out_valid=%0b, expected 1 0", in_ready, out_valid);
    end
    // R1/R7: empty table -> miss prefix, default action 0
    mk(16'h0800, 8'h45, 8'd6, SA, DA, 16'h1111, 16'h0050, 10);
    send(16'h0, 16'h0, 2'd0, 0, 6'd0, "R1/R7");
    wait_empty();
    // R10/R11: entry 3 exact, path functions 1 then 3
    entry(5'd3, SA, 32'hFFFFFFFF, DA, 32'hFFFFFFFF, 16'h1111, 16'h0050, 16'hFFFF, 16'hFFFF,
          8'd6, 8'hFF, 16'h0001, 16'h0031, 2'd1, 1);
    mk(16'h0800, 8'h45, 8'd6, SA, DA, 16'h1111, 16'h0050, 10);
    send(16'h0001, 16'h0031, 2'd1, 1, 6'd3, "R4/R10/R11");
    wait_empty();
    // R5: wildcard entry 1 overlaps entry 3
    entry(5'd1, 32'h0, 32'h0, 32'h0A000000, 32'hFFFFFF00, 16'h0, 16'h0, 16'h0, 16'h0,
          8'd0, 8'h00, 16'h0202, 16'h0002, 2'd2, 1);
    mk(16'h0800, 8'h45, 8'd6, SA, DA, 16'h1111, 16'h0050, 4);
    send(16'h0202, 16'h0002, 2'd2, 1, 6'd1, "R5");
    mk(16'h0800, 8'h45, 8'd6, 32'hC0A80102, 32'h0A000077, 16'h1111, 16'h0050, 0);
    send(16'h0202, 16'h0002, 2'd2, 1, 6'd1, "R4");
    wait_empty();
    // R6: invalidate entry 1
    cw(5'd1, 4'd8, 32'd0);
    mk(16'h0800, 8'h45, 8'd6, SA, DA, 16'h1111, 16'h0050, 3);
    send(16'h0001, 16'h0031, 2'd1, 1, 6'd3, "R6");
    mk(16'h0800, 8'h45, 8'd6, 32'hC0A80102, 32'h0A000077, 16'h1111, 16'h0050, 3);
    send(16'h0, 16'h0, 2'd0, 0, 6'd0, "R6");
    wait_empty();
    // R7: default action register
    cw(5'd0, 4'd15, 32'd1);
    mk(16'h0800, 8'h45, 8'd6, 32'hC0A80102, 32'h0A000077, 16'h1111, 16'h0050, 2);
    send(16'h0, 16'h0, 2'd1, 0, 6'd0, "R7");
    // R8: non-IPv4, wrong version, short IHL, truncated
    mk(16'h86DD, 8'h45, 8'd6, SA, DA, 16'h1111, 16'h0050, 5);
    send(16'h0, 16'h0, 2'd1, 0, 6'd0, "R8");
    mk(16'h0800, 8'h65, 8'd6, SA, DA, 16'h1111, 16'h0050, 5);
    send(16'h0, 16'h0, 2'd1, 0, 6'd0, "R8");
    mk(16'h0800, 8'h44, 8'd6, SA, DA, 16'h1111, 16'h0050, 5);
    send(16'h0, 16'h0, 2'd1, 0, 6'd0, "R8");
    mk(16'h0800, 8'h45, 8'd6, SA, DA, 16'h1111, 16'h0050, 0);
    while (pk.size() > 36) void'(pk.pop_back());
    send(16'h0, 16'h0, 2'd1, 0, 6'd0, "R8");
    mk(16'h0800, 8'h45, 8'd6, SA, DA, 16'h1111, 16'h0050, 0);
    while (pk.size() > 20) void'(pk.pop_back());
    send(16'h0, 16'h0, 2'd1, 0, 6'd0, "R8");
    wait_empty();
    // R3: ports follow IHL; non-TCP/UDP ports read as zero
    entry(5'd5, 32'h0, 32'h0, 32'h0, 32'h0, 16'h1234, 16'h0050, 16'hFFFF, 16'hFFFF,
          8'd6, 8'hFF, 16'h0505, 16'h4321, 2'd0, 1);
    entry(5'd6, 32'h0, 32'h0, 32'h0B0B0B0B, 32'hFFFFFFFF, 16'h0, 16'h0, 16'hFFFF, 16'hFFFF,
          8'd0, 8'h00, 16'h0606, 16'h0005, 2'd2, 1);
    mk(16'h0800, 8'h46, 8'd6, 32'h01020304, 32'h05060708, 16'h1234, 16'h0050, 6);
    send(16'h0505, 16'h4321, 2'd0, 1, 6'd5, "R3");
    mk(16'h0800, 8'h45, 8'd1, 32'h01020304, 32'h0B0B0B0B, 16'h1234, 16'h9999, 6);
    send(16'h0606, 16'h0005, 2'd2, 1, 6'd6, "R3");
    mk(16'h0800, 8'h45, 8'd17, 32'h01020304, 32'h0B0B0B0B, 16'h1234, 16'h9999, 6);
    send(16'h0, 16'h0, 2'd1, 0, 6'd0, "R3");
    wait_empty();
    // R9: random output stalls
    bp_en = 1;
    mk(16'h0800, 8'h45, 8'd6, SA, DA, 16'h1111, 16'h0050, 25);
    send(16'h0001, 16'h0031, 2'd1, 1, 6'd3, "R9");
    mk(16'h0800, 8'h46, 8'd6, 32'h01020304, 32'h05060708, 16'h1234, 16'h0050, 20);
    send(16'h0505, 16'h4321, 2'd0, 1, 6'd5, "R9");
    mk(16'h0800, 8'h45, 8'd6, SA, DA, 16'h1111, 16'h0050, 0);
    while (pk.size() > 30) void'(pk.pop_back());
    send(16'h0, 16'h0, 2'd1, 0, 6'd0, "R9");
    wait_empty();
    bp_en = 0;
    repeat (5) @(negedge clk);
    checks++;
    if (exp_q.size() != 0 || out_valid !== 1'b0) begin
      errors++;
      $display("FAIL R9: got %0d pending out_valid=%0b, expected 0 0", exp_q.size(), out_valid);
    end
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule